// File: doc/BRIEF.md
# Synthesizer Serial Control Register File

This block is the programming front end of a fractional-N frequency synthesizer. A host shifts 24-bit words in one bit at a time and then raises a load-enable line. The low three bits of the committed word pick the destination: the feedback divider register, the reference divider register or the control register. Words that carry any other address are dropped.

Every field is decoded combinationally from the three stored registers and driven to the divider, charge-pump and lock-detect logic. Power-down forces the counters into their hold state, three-states the charge pump and clears lock detect. The serial path keeps shifting and committing while power-down is active, and no stored value is lost.

A three-bit noise/spur code is gathered from control bits 15, 11 and 6 and selects the dither behaviour. A flag warns when the stored fractional value is larger than the stored modulus.

All inputs are taken as synchronous to `clk`. A small state machine follows the serial interface through three states:
- **SH_IDLE**: no bits have arrived since the last commit.
- **SH_SHIFT**: bits are being collected.
- **SH_COMMIT**: a one-cycle write strobe.

It makes these transitions:
- SH_IDLE goes to SH_SHIFT on a serial clock rise.
- SH_IDLE or SH_SHIFT goes to SH_COMMIT on a load-enable rise.
- SH_COMMIT goes to SH_SHIFT if a serial clock rise arrives in that cycle, and to SH_IDLE otherwise.

Top module: `sctl_regfile`

## Requirements
- R1: After the asynchronous reset every stored register is zero, so all field outputs are 0, the mode output is lowest-spur (code 0) and dither_en is 1.
- R2: On each rising edge of ser_clk, ser_data is shifted in MSB first. A commit uses only the last 24 bits shifted, so extra leading bits have no effect.
- R3: A rising edge of ser_le commits the word by the second clk edge after the edge that first samples ser_le high. Address bits [2:0]=000 write the feedback register: INT at [10:3] and FRAC at [22:11].
- R4: Address 001 writes the reference register: R count at [6:3], doubler enable at [7], modulus at [19:8], prescaler select at [20].
- R5: Address 010 writes the control register. Bit 3 drives cnt_hold, bit 4 drives cp_tristate and bit 5 drives pwr_down.
- R6: The mode code is {bit15, bit11, bit6} of the control register. Code 000 gives noise_mode 0 (lowest spur) with dither_en 1. Code 001 gives noise_mode 1 (low noise and spur) and code 111 gives noise_mode 2 (lowest noise), both with dither_en 0.
- R7: The reserved mode codes 010 through 110 decode to noise_mode 1 with dither_en 0.
- R8: While pwr_down is 1, cnt_hold, cp_tristate and lock_clr are all 1 whatever control bits 3 and 4 hold.
- R9: During power-down, words still shift in and commit, and the stored contents of the other registers are kept.
- R10: Words with address 011 through 111 change no register and no output.
- R11: frac_err is 1 exactly when the stored FRAC is greater than the stored modulus. It is 0 when the two are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, sampled on clk |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load enable; a rising edge commits the word |
| int_val | output | 8 | Feedback integer value |
| frac_val | output | 12 | Feedback fractional value |
| ref_cnt | output | 4 | Reference divide count |
| ref_dbl | output | 1 | Reference doubler enable |
| mod_val | output | 12 | Fractional modulus |
| presc_sel | output | 1 | Prescaler select |
| cnt_hold | output | 1 | Counters held in reset/load state |
| cp_tristate | output | 1 | Charge pump three-state |
| pwr_down | output | 1 | Power-down active |
| lock_clr | output | 1 | Lock-detect reset |
| noise_mode | output | 2 | 0 lowest spur, 1 low noise and spur, 2 lowest noise |
| dither_en | output | 1 | Fractional dither enable |
| frac_err | output | 1 | FRAC greater than modulus |

## Verification
The bench builds the block with its default widths: a 24-bit word, a 3-bit address, an 8-bit INT field, 12-bit FRAC and modulus fields and a 4-bit R count. With these values the tests can cover:
- the full 12-bit FRAC-to-modulus comparison, including the equal case at 0x800 and a case above it;
- leading surplus bits before a word;
- mode codes placed in the scattered bit positions, with both reserved and defined codes tried;
- an unused address (101) sent while power-down is active.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    localparam int WORD_W   = 24;
    localparam int ADDR_W   = 3;
    localparam int INT_W    = 8;
    localparam int FRAC_W   = 12;
    localparam int RCNT_W   = 4;
    localparam int MOD_W    = 12;
    localparam int NUM_REGS = 3;

    localparam int INT_LSB   = ADDR_W;
    localparam int FRAC_LSB  = INT_LSB + INT_W;
    localparam int RCNT_LSB  = ADDR_W;
    localparam int DBL_BIT   = RCNT_LSB + RCNT_W;
    localparam int MOD_LSB   = DBL_BIT + 1;
    localparam int PRESC_BIT = MOD_LSB + MOD_W;

    localparam int HOLD_BIT  = 3;
    localparam int TRI_BIT   = 4;
    localparam int PD_BIT    = 5;
    localparam int MODE_B0   = 6;
    localparam int MODE_B1   = 11;
    localparam int MODE_B2   = 15;

    localparam int IDX_FB  = 0;
    localparam int IDX_REF = 1;
    localparam int IDX_CTL = 2;

    typedef enum logic [1:0] {
        NM_LOWEST_SPUR    = 2'd0,
        NM_LOW_NOISE_SPUR = 2'd1,
        NM_LOWEST_NOISE   = 2'd2
    } noise_mode_e;

    typedef enum logic [1:0] {
        SH_IDLE   = 2'd0,
        SH_SHIFT  = 2'd1,
        SH_COMMIT = 2'd2
    } sh_state_e;
endpackage

// File: rtl/sctl_shift.sv
module sctl_shift
    import sctl_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_clk,
    input  logic         ser_data,
    input  logic         ser_le,
    output logic         wr_stb,
    output logic [W-1:0] wr_word
);
    sh_state_e    state, state_nx;
    logic         sclk_q, le_q;
    logic [W-1:0] shreg, word_q;
    logic         sclk_rise, le_rise;

    assign sclk_rise = ser_clk & ~sclk_q;
    assign le_rise   = ser_le & ~le_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            SH_IDLE:   if (le_rise) state_nx = SH_COMMIT;
                       else if (sclk_rise) state_nx = SH_SHIFT;
            SH_SHIFT:  if (le_rise) state_nx = SH_COMMIT;
            SH_COMMIT: state_nx = sclk_rise ? SH_SHIFT : SH_IDLE;
            default:   state_nx = SH_IDLE;
        endcase
    end

    // datapath: shift and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
            shreg  <= '0;
            word_q <= '0;
        end else begin
            sclk_q <= ser_clk;
            le_q   <= ser_le;
            if (sclk_rise) shreg  <= {shreg[W-2:0], ser_data};
            if (le_rise)   word_q <= shreg;
        end
    end

    // outputs
    always_comb begin
        wr_stb  = (state == SH_COMMIT);
        wr_word = word_q;
    end
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
    import sctl_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = ADDR_W,
    parameter int N  = NUM_REGS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic [W-1:0]        wr_word,
    output logic [N-1:0][W-1:0] reg_q
);
    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                reg_q[g] <= '0;
            else if (wr_stb && (wr_word[AW-1:0] == AW'(g)))
                reg_q[g] <= wr_word;
        end
    end
endmodule

// File: rtl/sctl_decode.sv
module sctl_decode
    import sctl_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0]      fb_q,
    input  logic [W-1:0]      ref_q,
    input  logic [W-1:0]      ctl_q,
    output logic [INT_W-1:0]  int_val,
    output logic [FRAC_W-1:0] frac_val,
    output logic [RCNT_W-1:0] ref_cnt,
    output logic              ref_dbl,
    output logic [MOD_W-1:0]  mod_val,
    output logic              presc_sel,
    output logic              cnt_hold,
    output logic              cp_tristate,
    output logic              pwr_down,
    output logic              lock_clr,
    output noise_mode_e       noise_mode,
    output logic              dither_en,
    output logic              frac_err
);
    logic [2:0] mode_code;

    always_comb begin
        int_val   = fb_q[INT_LSB +: INT_W];
        frac_val  = fb_q[FRAC_LSB +: FRAC_W];
        ref_cnt   = ref_q[RCNT_LSB +: RCNT_W];
        ref_dbl   = ref_q[DBL_BIT];
        mod_val   = ref_q[MOD_LSB +: MOD_W];
        presc_sel = ref_q[PRESC_BIT];

        pwr_down    = ctl_q[PD_BIT];
        cnt_hold    = ctl_q[HOLD_BIT] | pwr_down;
        cp_tristate = ctl_q[TRI_BIT] | pwr_down;
        lock_clr    = pwr_down;

        mode_code = {ctl_q[MODE_B2], ctl_q[MODE_B1], ctl_q[MODE_B0]};
        case (mode_code)
            3'b000:  noise_mode = NM_LOWEST_SPUR;
            3'b111:  noise_mode = NM_LOWEST_NOISE;
            default: noise_mode = NM_LOW_NOISE_SPUR;
        endcase
        dither_en = (noise_mode == NM_LOWEST_SPUR);
        frac_err  = (frac_val > mod_val);
    end
endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
    import sctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [INT_W-1:0]  int_val,
    output logic [FRAC_W-1:0] frac_val,
    output logic [RCNT_W-1:0] ref_cnt,
    output logic              ref_dbl,
    output logic [MOD_W-1:0]  mod_val,
    output logic              presc_sel,
    output logic              cnt_hold,
    output logic              cp_tristate,
    output logic              pwr_down,
    output logic              lock_clr,
    output logic [1:0]        noise_mode,
    output logic              dither_en,
    output logic              frac_err
);
    logic                          wr_stb;
    logic [WORD_W-1:0]             wr_word;
    logic [NUM_REGS-1:0][WORD_W-1:0] reg_q;
    noise_mode_e                   nm;

    sctl_shift #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .wr_stb(wr_stb), .wr_word(wr_word)
    );

    sctl_regs #(.W(WORD_W), .AW(ADDR_W), .N(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_word(wr_word),
        .reg_q(reg_q)
    );

    sctl_decode #(.W(WORD_W)) u_dec (
        .fb_q(reg_q[IDX_FB]), .ref_q(reg_q[IDX_REF]), .ctl_q(reg_q[IDX_CTL]),
        .int_val(int_val), .frac_val(frac_val), .ref_cnt(ref_cnt),
        .ref_dbl(ref_dbl), .mod_val(mod_val), .presc_sel(presc_sel),
        .cnt_hold(cnt_hold), .cp_tristate(cp_tristate), .pwr_down(pwr_down),
        .lock_clr(lock_clr), .noise_mode(nm), .dither_en(dither_en),
        .frac_err(frac_err)
    );

    assign noise_mode = nm;
endmodule

// File: rtl/sctl_regfile_chk.sv
module sctl_regfile_chk
    import sctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [WORD_W-1:0] wr_word,
    input logic [INT_W-1:0]  int_val,
    input logic [FRAC_W-1:0] frac_val,
    input logic [MOD_W-1:0]  mod_val,
    input logic              cnt_hold,
    input logic              cp_tristate,
    input logic              pwr_down,
    input logic              lock_clr,
    input logic [1:0]        noise_mode,
    input logic              dither_en,
    input logic              frac_err
);
    assert_pd_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (cnt_hold && cp_tristate && lock_clr));

    assert_dither_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dither_en |-> (noise_mode == 2'd0));

    assert_fb_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_word[ADDR_W-1:0] == 3'b000) |=>
        (int_val == $past(wr_word[INT_LSB +: INT_W]) &&
         frac_val == $past(wr_word[FRAC_LSB +: FRAC_W])));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_bad_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_word[ADDR_W-1:0] > 3'b010) |=>
        ($stable(int_val) && $stable(frac_val) && $stable(mod_val) &&
         $stable(pwr_down) && $stable(noise_mode)));

    assert_err_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frac_err) |-> $past(wr_stb));
endmodule

bind sctl_regfile sctl_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_word(wr_word),
    .int_val(int_val), .frac_val(frac_val), .mod_val(mod_val),
    .cnt_hold(cnt_hold), .cp_tristate(cp_tristate), .pwr_down(pwr_down),
    .lock_clr(lock_clr), .noise_mode(noise_mode), .dither_en(dither_en),
    .frac_err(frac_err)
);

// File: tb/sctl_regfile_test.sv
module sctl_regfile_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [7:0]  int_val;
    logic [11:0] frac_val, mod_val;
    logic [3:0]  ref_cnt;
    logic ref_dbl, presc_sel, cnt_hold, cp_tristate, pwr_down, lock_clr;
    logic [1:0] noise_mode;
    logic dither_en, frac_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sctl_regfile uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .int_val(int_val), .frac_val(frac_val),
        .ref_cnt(ref_cnt), .ref_dbl(ref_dbl), .mod_val(mod_val),
        .presc_sel(presc_sel), .cnt_hold(cnt_hold), .cp_tristate(cp_tristate),
        .pwr_down(pwr_down), .lock_clr(lock_clr), .noise_mode(noise_mode),
        .dither_en(dither_en), .frac_err(frac_err)
    );

    typedef struct packed {
        logic [7:0]  iv;
        logic [11:0] fv;
        logic [3:0]  rc;
        logic        db;
        logic [11:0] mv;
        logic        ps;
        logic        hold;
        logic        tri_s;
        logic        pd;
        logic        lk;
        logic [1:0]  nm;
        logic        dith;
        logic        err;
    } snap_t;

    typedef struct {
        snap_t exp;
        string tag;
    } item_t;

    item_t q[$];
    event  sent;
    logic [23:0] m_fb = '0, m_ref = '0, m_ctl = '0;

    function automatic snap_t model();
        snap_t s;
        logic [2:0] code;
        s.iv = m_fb[10:3];
        s.fv = m_fb[22:11];
        s.rc = m_ref[6:3];
        s.db = m_ref[7];
        s.mv = m_ref[19:8];
        s.ps = m_ref[20];
        s.pd = m_ctl[5];
        s.hold  = m_ctl[3] | s.pd;
        s.tri_s = m_ctl[4] | s.pd;
        s.lk = s.pd;
        code = {m_ctl[15], m_ctl[11], m_ctl[6]};
        s.nm = (code == 3'b000) ? 2'd0 : (code == 3'b111) ? 2'd2 : 2'd1;
        s.dith = (code == 3'b000);
        s.err = (s.fv > s.mv);
        return s;
    endfunction

    function automatic snap_t observe();
        return {int_val, frac_val, ref_cnt, ref_dbl, mod_val, presc_sel,
                cnt_hold, cp_tristate, pwr_down, lock_clr, noise_mode,
                dither_en, frac_err};
    endfunction

    task automatic compare(input snap_t exp, input string tag);
        snap_t act;
        act = observe();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_bit(input logic b);
        @(negedge clk) ser_data = b;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        repeat (2) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    // driver: shift a word, commit it, push the expected snapshot
    task automatic send(input logic [23:0] w, input int junk, input string tag);
        item_t it;
        for (int j = 0; j < junk; j++) pulse_bit(1'b1);
        for (int i = 23; i >= 0; i--) pulse_bit(w[i]);
        @(negedge clk) ser_le = 1'b1;
        repeat (3) @(negedge clk);
        ser_le = 1'b0;
        case (w[2:0])
            3'b000: m_fb  = w;
            3'b001: m_ref = w;
            3'b010: m_ctl = w;
            default: ;
        endcase
        it.exp = model();
        it.tag = tag;
        q.push_back(it);
        -> sent;
        repeat (4) @(negedge clk);
    endtask

    // monitor: pop and compare once the committed word has settled
    initial begin
        forever begin
            item_t it;
            @(sent);
            @(posedge clk);
            #1;
            it = q.pop_front();
            compare(it.exp, it.tag);
        end
    end

    function automatic logic [23:0] fbw(input logic [7:0] iv, input logic [11:0] fv);
        return {1'b0, fv, iv, 3'b000};
    endfunction

    function automatic logic [23:0] refw(input logic [3:0] rc, input logic db,
                                         input logic [11:0] mv, input logic ps);
        return {3'b000, ps, mv, db, rc, 3'b001};
    endfunction

    function automatic logic [23:0] ctlw(input logic [2:0] code, input logic hold,
                                         input logic tri_s, input logic pd);
        logic [23:0] w;
        w = 24'h000002;
        w[15] = code[2];
        w[11] = code[1];
        w[6]  = code[0];
        w[3]  = hold;
        w[4]  = tri_s;
        w[5]  = pd;
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        compare(model(), "R1 reset state");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send(fbw(8'hA5, 12'h123), 0, "R3 feedback write, R11 frac>mod=0");
        send(refw(4'd9, 1'b1, 12'h800, 1'b1), 0, "R4 reference write, R11 clear");
        send(ctlw(3'b001, 0, 0, 0), 0, "R6 code 001 low noise+spur");
        send(ctlw(3'b111, 0, 0, 0), 0, "R6 code 111 lowest noise");
        send(ctlw(3'b010, 0, 0, 0), 0, "R7 reserved code 010");
        send(ctlw(3'b100, 0, 0, 0), 0, "R7 reserved code 100");
        send(ctlw(3'b000, 1, 1, 0), 0, "R5 hold and tristate bits, R6 code 000");
        send(ctlw(3'b000, 0, 0, 1), 0, "R8 power-down forces outputs");
        send(fbw(8'h3C, 12'h900), 4, "R9 write during power-down, R2 surplus bits");
        send(24'hFFFFFD, 0, "R10 unused address 101 ignored");
        send(ctlw(3'b000, 0, 0, 0), 0, "R5 power-down released, R9 contents kept");
        send(fbw(8'h3C, 12'h800), 0, "R11 frac equal to mod");
        send(fbw(8'h01, 12'h801), 0, "R11 frac one above mod");

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule